// File: doc/BRIEF.md
# Processor Presence Bitmap with Hotplug Event

This block holds one presence bit per processor, packed eight to a byte: processor `id` lives in bit `id % 8` of byte `id / 8`. System firmware reads the map one byte at a time through a small read-only window. Plug and unplug requests arrive as a valid strobe plus a processor number. Each request that names a processor covered by the map updates its bit. It also raises a one-cycle event pulse. That pulse sets the shared processor-hotplug status flag of the general-purpose event bank, and the bank then raises the system control interrupt.

At reset the map is loaded from a parallel vector that describes the processors already fitted, and no event pulse is produced. Writes into the window are discarded. An access wider than one byte is not a legal window access.

Top module: `cpu_presence_map`

## Requirements
- R1: While `rst_n` is low the map is loaded from `init_present` (bit `k` of the vector is processor `k`), `rd_data` is 0x00 and `cpu_evt_pulse` is 0; in the first cycle after release no pulse is present.
- R2: A byte read (`rd_en`=1, `acc_wide`=0) at window offset `N` presents bits `8N+7..8N` of the map on `rd_data` from the clock edge that samples it; `rd_data` then holds until the next read.
- R3: A plug request (`plug_valid`=1) for an in-range `plug_id` sets bit `plug_id % 8` of byte `plug_id / 8`, visible to reads from the following cycle.
- R4: An unplug request (`unplug_valid`=1) for an in-range `unplug_id` clears that processor's bit.
- R5: Any cycle that carries at least one in-range plug or unplug request gives `cpu_evt_pulse`=1 for exactly the next cycle; a cycle with none gives 0. Two requests in one cycle give a single pulse.
- R6: `wr_en` and `wr_data` change neither the map, `rd_data` nor `cpu_evt_pulse`.
- R7: A read with `acc_wide`=1 returns 0x00 and leaves the map unchanged.
- R8: A request whose processor number is at or above `NUM_BYTES*8` is dropped. It changes no bit and causes no pulse.
- R9: If plug and unplug name the same processor in one cycle, the bit ends set. If they name different processors, both are applied.
- R10: A read in the same cycle as a request returns the map as it stood before that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the initial map |
| init_present | input | NUM_BYTES*8 | Processors present at reset, bit k = processor k |
| plug_valid | input | 1 | Plug request strobe |
| plug_id | input | ID_W | Processor number of the plug request |
| unplug_valid | input | 1 | Unplug request strobe |
| unplug_id | input | ID_W | Processor number of the unplug request |
| rd_en | input | 1 | Window read strobe |
| wr_en | input | 1 | Window write strobe (discarded) |
| acc_wide | input | 1 | 1 = access wider than one byte (illegal) |
| win_addr | input | $clog2(NUM_BYTES) | Byte offset within the window |
| wr_data | input | 8 | Write data (discarded) |
| rd_data | output | 8 | Byte returned by the last read |
| cpu_evt_pulse | output | 1 | One-cycle hotplug status pulse toward the event bank |

## Verification
Directed cases drive the first and last processor numbers, a plug and an unplug of the same processor in one cycle, requests paired with a read of the affected byte, writes of random data, and wide reads. These separate the plug-wins rule from its inverse, and old-value reads from new-value reads. A randomly seeded stream then mixes plug, unplug, read and write traffic. It runs against a map of 256 processors and against a second instance of 128 processors fed the same stimulus. In the smaller instance the upper half of the processor numbers is out of range. That shows dropped requests apart from accepted ones through both the pulse and later full readbacks.

// File: rtl/presence_pkg.sv
package presence_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] pbyte_t;
endpackage

// File: rtl/presence_id_decode.sv
module presence_id_decode #(
    parameter int NUM_CPUS = 256,
    parameter int ID_W     = 8
) (
    input  logic                valid,
    input  logic [ID_W-1:0]     id,
    output logic [NUM_CPUS-1:0] mask,
    output logic                hit
);
    // a request counts only when its number falls inside the map
    assign hit = valid && (int'(id) < NUM_CPUS);

    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_bit
        assign mask[i] = hit && (int'(id) == i);
    end
endmodule

// File: rtl/presence_byte_mux.sv
module presence_byte_mux
    import presence_pkg::*;
#(
    parameter int NUM_BYTES = 32,
    localparam int SEL_W    = $clog2(NUM_BYTES)
) (
    input  logic [NUM_BYTES*BYTE_W-1:0] map,
    input  logic [SEL_W-1:0]            sel,
    output pbyte_t                      byte_o
);
    pbyte_t lanes [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        assign lanes[g] = map[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lanes[sel];
endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map
    import presence_pkg::*;
#(
    parameter int NUM_BYTES = 32,
    parameter int ID_W      = 8,
    localparam int NUM_CPUS = NUM_BYTES * BYTE_W,
    localparam int ADDR_W   = $clog2(NUM_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CPUS-1:0] init_present,
    input  logic                plug_valid,
    input  logic [ID_W-1:0]     plug_id,
    input  logic                unplug_valid,
    input  logic [ID_W-1:0]     unplug_id,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic                acc_wide,
    input  logic [ADDR_W-1:0]   win_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                cpu_evt_pulse
);
    localparam int N_SRC = 2;   // index 0: plug, index 1: unplug

    typedef struct packed {
        logic [NUM_CPUS-1:0] map;
        pbyte_t              rdata;
        logic                evt;
    } state_t;

    state_t s_d, s_q;

    logic                valid_v [N_SRC];
    logic [ID_W-1:0]     id_v    [N_SRC];
    logic [NUM_CPUS-1:0] mask_v  [N_SRC];
    logic                hit_v   [N_SRC];
    pbyte_t              win_byte;

    // window writes are accepted and thrown away
    logic wr_ignore_unused;
    assign wr_ignore_unused = ^{wr_en, wr_data};

    assign valid_v[0] = plug_valid;
    assign id_v[0]    = plug_id;
    assign valid_v[1] = unplug_valid;
    assign id_v[1]    = unplug_id;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        presence_id_decode #(
            .NUM_CPUS (NUM_CPUS),
            .ID_W     (ID_W)
        ) u_dec (
            .valid (valid_v[s]),
            .id    (id_v[s]),
            .mask  (mask_v[s]),
            .hit   (hit_v[s])
        );
    end

    presence_byte_mux #(
        .NUM_BYTES (NUM_BYTES)
    ) u_mux (
        .map    (s_q.map),
        .sel    (win_addr),
        .byte_o (win_byte)
    );

    always_comb begin
        s_d     = s_q;
        // clear first, then set: plug wins on a shared number
        s_d.map = (s_q.map & ~mask_v[1]) | mask_v[0];
        s_d.evt = hit_v[0] | hit_v[1];
        if (rd_en) begin
            s_d.rdata = acc_wide ? '0 : win_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.map   <= init_present;
            s_q.rdata <= '0;
            s_q.evt   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data       = s_q.rdata;
    assign cpu_evt_pulse = s_q.evt;
endmodule

// File: rtl/presence_map_checker.sv
module presence_map_checker
    import presence_pkg::*;
#(
    parameter int NUM_BYTES = 32,
    parameter int ID_W      = 8,
    localparam int NUM_CPUS = NUM_BYTES * BYTE_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                plug_valid,
    input logic [ID_W-1:0]     plug_id,
    input logic                unplug_valid,
    input logic [ID_W-1:0]     unplug_id,
    input logic                rd_en,
    input logic                acc_wide,
    input logic [BYTE_W-1:0]   rd_data,
    input logic                cpu_evt_pulse,
    input logic [NUM_CPUS-1:0] map_q
);
    logic plug_in, unplug_in;
    assign plug_in   = plug_valid   && (int'(plug_id)   < NUM_CPUS);
    assign unplug_in = unplug_valid && (int'(unplug_id) < NUM_CPUS);

    assert_plug_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        plug_in |=> map_q[$past(plug_id)]);

    assert_unplug_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unplug_in && !(plug_valid && plug_id == unplug_id)) |=> !map_q[$past(unplug_id)]);

    assert_pulse_follows_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_in || unplug_in) |=> cpu_evt_pulse);

    assert_no_pulse_without_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(plug_in || unplug_in) |=> !cpu_evt_pulse);

    assert_wide_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_wide) |=> (rd_data == '0));

    assert_rdata_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_idle_map_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(plug_valid || unplug_valid) |=> $stable(map_q));
endmodule

bind cpu_presence_map presence_map_checker #(
    .NUM_BYTES (NUM_BYTES),
    .ID_W      (ID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .plug_valid    (plug_valid),
    .plug_id       (plug_id),
    .unplug_valid  (unplug_valid),
    .unplug_id     (unplug_id),
    .rd_en         (rd_en),
    .acc_wide      (acc_wide),
    .rd_data       (rd_data),
    .cpu_evt_pulse (cpu_evt_pulse),
    .map_q         (s_q.map)
);

// File: tb/tb_cpu_presence_map.sv
`timescale 1ns/1ps
module tb_cpu_presence_map;
    localparam int NB  = 32;
    localparam int NBS = 16;
    localparam int NC  = NB * 8;
    localparam int NCS = NBS * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] init_present;
    logic          plug_valid = 0, unplug_valid = 0;
    logic [7:0]    plug_id = 0, unplug_id = 0;
    logic          rd_en = 0, wr_en = 0, acc_wide = 0;
    logic [4:0]    win_addr = 0;
    logic [7:0]    wr_data = 0;
    logic [7:0]    rd_data, rd_data_s;
    logic          pulse, pulse_s;

    int vectors = 0, miscompares = 0;
    bit done = 0;

    logic [NC-1:0]  exp_big;
    logic [NCS-1:0] exp_small;
    logic [7:0]     exp_rd = 0, exp_rd_s = 0;

    always #5 clk = ~clk;

    cpu_presence_map #(.NUM_BYTES(NB), .ID_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .init_present(init_present),
        .plug_valid(plug_valid), .plug_id(plug_id),
        .unplug_valid(unplug_valid), .unplug_id(unplug_id),
        .rd_en(rd_en), .wr_en(wr_en), .acc_wide(acc_wide),
        .win_addr(win_addr), .wr_data(wr_data),
        .rd_data(rd_data), .cpu_evt_pulse(pulse));

    cpu_presence_map #(.NUM_BYTES(NBS), .ID_W(8)) dut_small (
        .clk(clk), .rst_n(rst_n), .init_present(init_present[NCS-1:0]),
        .plug_valid(plug_valid), .plug_id(plug_id),
        .unplug_valid(unplug_valid), .unplug_id(unplug_id),
        .rd_en(rd_en), .wr_en(wr_en), .acc_wide(acc_wide),
        .win_addr(win_addr[3:0]), .wr_data(wr_data),
        .rd_data(rd_data_s), .cpu_evt_pulse(pulse_s));

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] upd_big(logic [NC-1:0] m, logic pv, logic [7:0] pid,
                                              logic uv, logic [7:0] uid);
        if (uv) m[uid] = 1'b0;
        if (pv) m[pid] = 1'b1;
        return m;
    endfunction

    function automatic logic [NCS-1:0] upd_small(logic [NCS-1:0] m, logic pv, logic [7:0] pid,
                                                 logic uv, logic [7:0] uid);
        if (uv && uid < NCS) m[uid[6:0]] = 1'b0;
        if (pv && pid < NCS) m[pid[6:0]] = 1'b1;
        return m;
    endfunction

    // one cycle: drive at negedge, sample at the following negedge
    task automatic step(string req, logic pv, logic [7:0] pid, logic uv, logic [7:0] uid,
                        logic re, logic [4:0] off, logic wide, logic we, logic [7:0] wd);
        logic ep, eps;
        plug_valid = pv; plug_id = pid; unplug_valid = uv; unplug_id = uid;
        rd_en = re; win_addr = off; acc_wide = wide; wr_en = we; wr_data = wd;
        ep  = pv | uv;
        eps = (pv && pid < NCS) | (uv && uid < NCS);
        if (re) begin   // R10: read sees the map before this cycle's requests
            exp_rd   = wide ? 8'h00 : exp_big[off*8 +: 8];
            exp_rd_s = wide ? 8'h00 : exp_small[off[3:0]*8 +: 8];
        end
        exp_big   = upd_big(exp_big, pv, pid, uv, uid);
        exp_small = upd_small(exp_small, pv, pid, uv, uid);
        @(posedge clk);
        @(negedge clk);
        plug_valid = 0; unplug_valid = 0; rd_en = 0; wr_en = 0; acc_wide = 0;
        chk({req, " pulse"}, {7'b0, pulse}, {7'b0, ep});
        chk({req, " pulse small"}, {7'b0, pulse_s}, {7'b0, eps});
        chk({req, " rd_data"}, rd_data, exp_rd);
        chk({req, " rd_data small"}, rd_data_s, exp_rd_s);
    endtask

    task automatic rd(string req, logic [4:0] off);
        step(req, 0, 0, 0, 0, 1, off, 0, 0, 0);
    endtask

    task automatic readback(string req);
        for (int b = 0; b < NB; b++) rd(req, 5'(b));
    endtask

    initial begin
        void'($urandom(32'd7341));
        for (int w = 0; w < NC/32; w++) init_present[w*32 +: 32] = $urandom;
        exp_big   = init_present;
        exp_small = init_present[NCS-1:0];
        plug_valid = 1; plug_id = 8'd3;   // request during reset must be ignored
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pulse", {7'b0, pulse}, 8'h00);
        chk("R1 reset rd_data", rd_data, 8'h00);
        plug_valid = 0;
        rst_n = 1;
        @(negedge clk);
        chk("R1 first cycle pulse", {7'b0, pulse}, 8'h00);
        readback("R1 R2 init readback");

        step("R3 plug id0", 1, 8'd0, 0, 0, 0, 0, 0, 0, 0);
        step("R3 plug id255", 1, 8'd255, 0, 0, 0, 0, 0, 0, 0);
        rd("R3 byte0", 5'd0);
        rd("R3 byte31", 5'd31);
        step("R4 unplug id0", 0, 0, 1, 8'd0, 0, 0, 0, 0, 0);
        step("R4 unplug id255", 0, 0, 1, 8'd255, 0, 0, 0, 0, 0);
        rd("R4 byte0", 5'd0);
        rd("R4 byte31", 5'd31);
        step("R9 same id", 1, 8'd77, 1, 8'd77, 0, 0, 0, 0, 0);
        rd("R9 byte9", 5'd9);
        step("R9 diff ids", 1, 8'd20, 1, 8'd21, 0, 0, 0, 0, 0);
        rd("R9 byte2", 5'd2);
        step("R10 read with plug", 1, 8'd100, 0, 0, 1, 5'd12, 0, 0, 0);
        rd("R10 after", 5'd12);
        step("R10 read with unplug", 0, 0, 1, 8'd100, 1, 5'd12, 0, 0, 0);
        rd("R10 after unplug", 5'd12);
        step("R8 out of range small", 1, 8'd200, 0, 0, 0, 0, 0, 0, 0);
        step("R8 out of range unplug", 0, 0, 1, 8'd130, 0, 0, 0, 0, 0);
        for (int k = 0; k < 8; k++) step("R6 write", 0, 0, 0, 0, 0, 5'(k*4), 0, 1, 8'($urandom));
        step("R7 wide read", 0, 0, 0, 0, 1, 5'd1, 1, 0, 0);
        step("R7 wide read with write", 0, 0, 0, 0, 1, 5'd30, 1, 1, 8'hFF);
        readback("R6 R7 R8 readback");

        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 9);
            step("R2/R3/R4/R5/R9 random",
                 r < 4, 8'($urandom), (r > 2 && r < 7), 8'($urandom),
                 $urandom_range(0, 1) == 1, 5'($urandom), $urandom_range(0, 7) == 0,
                 $urandom_range(0, 3) == 0, 8'($urandom));
        end
        readback("R3 R4 R8 final readback");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog all-requirements actual=hung expected=complete");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule